// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that runs entirely on its own low-speed clock. Software reaches it through a single narrow write port. One address carries 16-bit key codes. The other two addresses hold the prescaler select and the 12-bit reload value. Those two registers only accept writes while a key has opened them. A start key launches a down-counter from the reload value. The counter steps once per divided clock period, and a feed key puts the full reload value back and restarts the division.

If the count runs out before the next feed, the block raises a reset request for exactly one clock. It then parks in a halted state until a system reset. Software cannot stop a running watchdog. Unknown key values are dropped. Prescaler codes above the largest divider act as the largest divider.

The control is a four-state machine:
- IDLE moves to RUN on a start key (transition *launch*).
- RUN moves to FIRE when a divider tick arrives while the count is at one or zero and no feed is present (transition *expire*). A feed in RUN is the self-loop *refresh*.
- FIRE moves to HALT on the next edge (transition *settle*).
- HALT only loops (*park*).

Top module: `iwd_watchdog`

## Requirements
- R1: After reset the block is idle, `count_o` is 0 and `rst_req_o` is low. The reload register holds 0xFFF and the prescaler code is 0, so a start with no configuration gives a count of 0xFFF that first drops 4 cycles later.
- R2: A write to address 0 is a key. 0xCCCC starts the watchdog, 0xAAAA feeds it, 0x5555 opens the configuration registers and 0x0000 closes them. Every other value is ignored, and a feed while idle is ignored.
- R3: A write to address 1 sets the prescaler code from `wr_data[2:0]`, and a write to address 2 sets the reload value from `wr_data[11:0]`. Each takes effect on the write edge only while the registers are open. While they are closed these writes change nothing.
- R4: On the edge that accepts a start key, `count_o` takes the reload value and the clock divider begins from zero.
- R5: Prescaler code n (0 to 6) divides by 2^(n+2). While running, the count holds or drops by exactly one, and it drops once every 2^(n+2) cycles.
- R6: Prescaler codes 7 and above divide the same as code 6, which is by 256.
- R7: With reload value L and divide ratio D, `rst_req_o` is high in the cycle after the max(L,1)*D-th edge following the start or feed edge. A reload value of 0 acts as 1.
- R8: A feed while running loads the reload value into `count_o` and restarts the divider from zero, so the next decrement comes D cycles after the feed edge.
- R9: Once started, the close, open and start keys do not alter the countdown. The watchdog never returns to idle without a reset.
- R10: `rst_req_o` lasts one cycle. Afterwards `count_o` stays 0, no further request is made and all keys are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ls | input | 1 | Low-speed watchdog clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | 0 key, 1 prescaler code, 2 reload value, 3 unused |
| wr_data | input | 16 | Write data |
| count_o | output | 12 | Current value of the down-counter |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
Each accepted write lands on the rising edge where `wr_en` is sampled. Reload and prescaler values are visible one edge later, and a start or feed shows its reload value in `count_o` right after that same edge. The first decrement follows D edges after the start or feed, and the reset request appears after edge max(L,1)*D and drops one edge later. The bench drives every write in a falling-edge window and samples only on falling edges. It counts edges from the write edge, so each expected value is checked in the exact cycle it is due, and the cycle just before is checked as well.

// File: rtl/iwd_pkg.sv
package iwd_pkg;
    localparam int KEY_W  = 16;
    localparam int ADDR_W = 2;

    localparam logic [KEY_W-1:0] KEY_START = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_FEED  = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_OPEN  = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_SHUT  = 16'h0000;

    localparam logic [ADDR_W-1:0] ADDR_KEY = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DIV = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_RLD = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2,
        ST_HALT = 2'd3
    } wstate_e;
endpackage

// File: rtl/iwd_keyregs.sv
module iwd_keyregs
    import iwd_pkg::*;
#(
    parameter int RLD_W  = 12,
    parameter int PSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [KEY_W-1:0]  wr_data,
    output logic              start_p,
    output logic              feed_p,
    output logic              open_q,
    output logic [PSEL_W-1:0] psel_q,
    output logic [RLD_W-1:0]  rld_q
);
    logic key_hit;

    assign key_hit = wr_en && (wr_addr == ADDR_KEY);
    assign start_p = key_hit && (wr_data == KEY_START);
    assign feed_p  = key_hit && (wr_data == KEY_FEED);

    // Unlock flag: only the open and shut codes move it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (key_hit && (wr_data == KEY_OPEN)) begin
            open_q <= 1'b1;
        end else if (key_hit && (wr_data == KEY_SHUT)) begin
            open_q <= 1'b0;
        end
    end

    // Protected configuration registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psel_q <= '0;
            rld_q  <= '1;
        end else if (wr_en && open_q) begin
            if (wr_addr == ADDR_DIV) begin
                psel_q <= wr_data[PSEL_W-1:0];
            end
            if (wr_addr == ADDR_RLD) begin
                rld_q <= wr_data[RLD_W-1:0];
            end
        end
    end
endmodule

// File: rtl/iwd_divider.sv
module iwd_divider #(
    parameter int PSEL_W     = 3,
    parameter int BASE_SHIFT = 2,
    parameter int MAX_SEL    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);
    localparam int DIV_W = BASE_SHIFT + MAX_SEL;

    logic [PSEL_W-1:0] eff_sel;
    logic [DIV_W:0]    span;
    logic [DIV_W-1:0]  limit;
    logic [DIV_W-1:0]  div_q;

    // Codes beyond the largest divider clamp to it, when the field can hold them.
    if (((2 ** PSEL_W) - 1) > MAX_SEL) begin : g_clamp
        assign eff_sel = (psel > PSEL_W'(MAX_SEL)) ? PSEL_W'(MAX_SEL) : psel;
    end else begin : g_pass
        assign eff_sel = psel;
    end

    assign span  = (DIV_W + 1)'(1) << (32'(eff_sel) + BASE_SHIFT);
    assign limit = DIV_W'(span - (DIV_W + 1)'(1));
    assign tick  = run && !restart && (div_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= (div_q == limit) ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/iwd_down.sv
module iwd_down #(
    parameter int RLD_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RLD_W-1:0] load_val,
    input  logic             dec,
    output logic [RLD_W-1:0] cnt_q,
    output logic             le_one
);
    assign le_one = (cnt_q <= RLD_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/iwd_watchdog.sv
module iwd_watchdog
    import iwd_pkg::*;
#(
    parameter int RLD_W      = 12,
    parameter int PSEL_W     = 3,
    parameter int BASE_SHIFT = 2,
    parameter int MAX_SEL    = 6
) (
    input  logic              clk_ls,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [15:0]       wr_data,
    output logic [RLD_W-1:0]  count_o,
    output logic              rst_req_o
);
    wstate_e           state_q;
    wstate_e           state_nx;
    logic              start_p;
    logic              feed_p;
    logic              open_q;
    logic [PSEL_W-1:0] psel_q;
    logic [RLD_W-1:0]  rld_q;
    logic              tick;
    logic              le_one;
    logic              do_load;
    logic              do_dec;
    logic              run_en;

    iwd_keyregs #(.RLD_W(RLD_W), .PSEL_W(PSEL_W)) u_keys (
        .clk     (clk_ls),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .start_p (start_p),
        .feed_p  (feed_p),
        .open_q  (open_q),
        .psel_q  (psel_q),
        .rld_q   (rld_q)
    );

    iwd_divider #(.PSEL_W(PSEL_W), .BASE_SHIFT(BASE_SHIFT), .MAX_SEL(MAX_SEL)) u_div (
        .clk     (clk_ls),
        .rst_n   (rst_n),
        .run     (run_en),
        .restart (do_load),
        .psel    (psel_q),
        .tick    (tick)
    );

    iwd_down #(.RLD_W(RLD_W)) u_cnt (
        .clk      (clk_ls),
        .rst_n    (rst_n),
        .load     (do_load),
        .load_val (rld_q),
        .dec      (do_dec),
        .cnt_q    (count_o),
        .le_one   (le_one)
    );

    // State register.
    always_ff @(posedge clk_ls or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transitions: launch, refresh, expire, settle, park.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (start_p) state_nx = ST_RUN;
            ST_RUN:  if (!feed_p && tick && le_one) state_nx = ST_FIRE;
            ST_FIRE: state_nx = ST_HALT;
            ST_HALT: state_nx = ST_HALT;
            default: state_nx = ST_HALT;
        endcase
    end

    // Outputs per state.
    always_comb begin
        do_load   = 1'b0;
        do_dec    = 1'b0;
        run_en    = 1'b0;
        rst_req_o = 1'b0;
        unique case (state_q)
            ST_IDLE: do_load = start_p;
            ST_RUN: begin
                run_en  = 1'b1;
                do_load = feed_p;
                do_dec  = tick && !feed_p;
            end
            ST_FIRE: rst_req_o = 1'b1;
            ST_HALT: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/iwd_checker.sv
module iwd_checker #(
    parameter int RLD_W  = 12,
    parameter int PSEL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [15:0]       wr_data,
    input logic [RLD_W-1:0]  count_o,
    input logic              rst_req_o,
    input logic [1:0]        state,
    input logic              open_q,
    input logic [PSEL_W-1:0] psel_q,
    input logic [RLD_W-1:0]  rld_q
);
    logic reload_key;
    assign reload_key = wr_en && (wr_addr == 2'd0) &&
                        ((wr_data == 16'hCCCC) || (wr_data == 16'hAAAA));

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd3) |=> ((state == 2'd3) && (count_o == '0) && !rst_req_o));

    assert_no_return_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != 2'd0) |=> (state != 2'd0));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !reload_key |=> ((count_o == $past(count_o)) ||
                         (count_o == $past(count_o) - RLD_W'(1))));

    assert_locked_rld_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_q && wr_en && (wr_addr == 2'd2)) |=> $stable(rld_q));

    assert_locked_psel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_q && wr_en && (wr_addr == 2'd1)) |=> $stable(psel_q));

    assert_req_from_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> ($past(state) == 2'd1));
endmodule

bind iwd_watchdog iwd_checker #(.RLD_W(RLD_W), .PSEL_W(PSEL_W)) u_chk (
    .clk       (clk_ls),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .count_o   (count_o),
    .rst_req_o (rst_req_o),
    .state     (state_q),
    .open_q    (open_q),
    .psel_q    (psel_q),
    .rld_q     (rld_q)
);

// File: tb/tb_iwd_watchdog.sv
module tb_iwd_watchdog;
    localparam int CLK_PERIOD = 10;

    logic        clk_ls = 1'b0;
    logic        rst_n  = 1'b0;
    logic        wr_en  = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [11:0] count_o;
    logic        rst_req_o;

    int total = 0;
    int bad   = 0;

    iwd_watchdog dut (
        .clk_ls    (clk_ls),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .count_o   (count_o),
        .rst_req_o (rst_req_o)
    );

    always #(CLK_PERIOD / 2) clk_ls = ~clk_ls;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk_ls);
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk_ls);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk_ls);
        rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
    endtask

    task automatic setup(input int sel, input int rl);
        do_reset();
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'(sel));
        wr(2'd2, 16'(rl));
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 count after reset", int'(count_o), 0);
        chk("R1 request after reset", int'(rst_req_o), 0);
        wr(2'd0, 16'hCCCC);
        chk("R1 default reload", int'(count_o), 12'hFFF);
        wait_n(3);
        chk("R1 default divide hold", int'(count_o), 12'hFFF);
        wait_n(1);
        chk("R1 default divide step", int'(count_o), 12'hFFE);
    endtask

    task automatic t_keys_idle();
        do_reset();
        wr(2'd0, 16'h1234);
        wr(2'd0, 16'hAAAA);
        wr(2'd0, 16'hCCCD);
        wait_n(20);
        chk("R2 unknown key and idle feed", int'(count_o), 0);
        chk("R2 no request", int'(rst_req_o), 0);
    endtask

    task automatic t_lock();
        do_reset();
        wr(2'd2, 16'd5);
        wr(2'd1, 16'd3);
        wr(2'd0, 16'hCCCC);
        chk("R3 locked reload ignored", int'(count_o), 12'hFFF);
        wait_n(4);
        chk("R3 locked prescaler ignored", int'(count_o), 12'hFFE);
        do_reset();
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'h1234);
        wr(2'd2, 16'd3);
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'd9);
        wr(2'd0, 16'hCCCC);
        chk("R3 open write taken, closed write dropped", int'(count_o), 3);
        wait_n(11);
        chk("R7 no request one cycle early", int'(rst_req_o), 0);
        wait_n(1);
        chk("R7 request after 12 cycles", int'(rst_req_o), 1);
    endtask

    task automatic t_timeout(input int sel, input int rl, input int div, input string tag);
        int eff;
        eff = (rl == 0) ? 1 : rl;
        setup(sel, rl);
        wr(2'd0, 16'hCCCC);
        chk({tag, " R4 start loads reload"}, int'(count_o), rl);
        if (rl > 1) begin
            wait_n(div - 1);
            chk({tag, " R5 hold before tick"}, int'(count_o), rl);
            wait_n(1);
            chk({tag, " R5 step at tick"}, int'(count_o), rl - 1);
            wait_n(eff * div - div - 1);
        end else begin
            wait_n(eff * div - 1);
        end
        chk({tag, " R7 quiet before expiry"}, int'(rst_req_o), 0);
        wait_n(1);
        chk({tag, " R7 request at expiry"}, int'(rst_req_o), 1);
        chk({tag, " R7 count zero"}, int'(count_o), 0);
        wait_n(1);
        chk({tag, " R10 single pulse"}, int'(rst_req_o), 0);
        wr(2'd0, 16'hAAAA);
        wr(2'd0, 16'hCCCC);
        chk({tag, " R10 keys ignored when halted"}, int'(count_o), 0);
        wait_n(300);
        chk({tag, " R10 stays halted"}, int'(rst_req_o) + int'(count_o), 0);
    endtask

    task automatic t_feed();
        setup(0, 3);
        wr(2'd0, 16'hCCCC);
        wait_n(9);
        chk("R8 count before feed", int'(count_o), 1);
        wr(2'd0, 16'hAAAA);
        chk("R8 feed reloads", int'(count_o), 3);
        wait_n(3);
        chk("R8 divider restarted", int'(count_o), 3);
        wait_n(1);
        chk("R8 first step after feed", int'(count_o), 2);
        wait_n(7);
        chk("R8 quiet before expiry", int'(rst_req_o), 0);
        wait_n(1);
        chk("R8 expiry after feed", int'(rst_req_o), 1);
    endtask

    task automatic t_nostop();
        setup(0, 3);
        wr(2'd0, 16'hCCCC);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'hCCCC);
        chk("R9 start key not a reload", int'(count_o), 3);
        wait_n(1);
        chk("R9 countdown continues", int'(count_o), 2);
        wait_n(7);
        chk("R9 quiet before expiry", int'(rst_req_o), 0);
        wait_n(1);
        chk("R9 expiry not stopped", int'(rst_req_o), 1);
    endtask

    initial begin
        t_reset();
        t_keys_idle();
        t_lock();
        t_timeout(0, 3, 4, "sel0");
        t_timeout(2, 1, 16, "sel2");
        t_timeout(6, 2, 256, "sel6 R5");
        t_timeout(7, 1, 256, "sel7 R6");
        t_timeout(0, 0, 4, "zero R7");
        t_feed();
        t_nostop();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule